// File: doc/BRIEF.md
# Read-response count-function compactor

This block condenses the serial read results of a pattern-sensitive memory test into three counts instead of one signature. It counts the reads that return 1, the places where a read of 0 is directly followed by a read of 1, and the places where consecutive reads differ in either direction. Strings with the same number of ones but different ordering (0011 versus 1100, 1010 and 0101) thus end up with different count triples, which one count alone could not separate.

A test sequencer drives `rd_valid` with `rd_bit` for every read and pulses `test_end` once the last read has been issued. On the cycle after that strobe, the block raises `done` for one cycle and compares its counts against the three expected-count inputs. `mismatch` gives the verdict in that cycle and keeps it until reset. After the strobe, the block ignores all further reads and strobes until reset, and reset is the only way to start a new run.

The control is a four-state machine. `PH_EMPTY` means no read has been accepted yet. `PH_STREAM` means at least one read has been accepted. `PH_JUDGE` is the single verdict cycle. `PH_CLOSED` holds the result.

Its transitions are:
- EMPTY→STREAM on a read without a strobe.
- EMPTY→JUDGE or STREAM→JUDGE on `test_end`.
- JUDGE→CLOSED always.
- CLOSED→CLOSED always.
- Reset returns the machine to EMPTY.

Top module: `cfc_compactor`

## Requirements
- R1: While `rst_n` is low, and after it is released, all three counts read 0 and `done` and `mismatch` are 0.
- R2: An accepted read with `rd_bit`=1 raises `cnt_ones` by one, visible in the cycle after the read.
- R3: An accepted read of 1 whose previous accepted read was 0 raises `cnt_rises` by one. `cnt_rises` never exceeds `cnt_trans`.
- R4: An accepted read whose value differs from the previous accepted read raises `cnt_trans` by one.
- R5: The first accepted read after reset changes neither `cnt_rises` nor `cnt_trans`.
- R6: Cycles with `rd_valid`=0 change no count and do not break pairing, so the next accepted read is paired with the last accepted one.
- R7: Each count stops at 2^CNT_W−1 and stays there instead of wrapping.
- R8: A read in the same cycle as `test_end` is still counted. `done` is 1 in exactly the cycle after the accepted strobe and 0 otherwise.
- R9: While `done` is 1, `mismatch` is 1 exactly when one or more counts differ from `exp_ones`, `exp_rises` or `exp_trans`, sampled in that cycle. From the next cycle on, `mismatch` holds that value until reset.
- R10: After the accepted strobe, reads and further strobes are ignored. The counts stay constant and `done` does not pulse again.
- R11: With expected counts (2,1,1), the string 0011 gives `mismatch`=0, while 1100, 1010 and 0101 each give `mismatch`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_valid | input | 1 | A read result is present this cycle |
| rd_bit | input | 1 | Read result bit |
| test_end | input | 1 | Last read issued; request the verdict |
| exp_ones | input | CNT_W | Expected number of ones |
| exp_rises | input | CNT_W | Expected number of 0-to-1 steps |
| exp_trans | input | CNT_W | Expected number of value changes |
| cnt_ones | output | CNT_W | Ones counted so far |
| cnt_rises | output | CNT_W | 0-to-1 steps counted so far |
| cnt_trans | output | CNT_W | Value changes counted so far |
| done | output | 1 | One-cycle verdict strobe |
| mismatch | output | 1 | Verdict: some count differs from expected |

## Verification
The bench builds the block with CNT_W=3, so every count saturates at 7. A stream of twenty alternating reads therefore drives all three counters into their ceiling and then holds them there. With this width the four-bit example strings are still represented exactly, so both the ordering-sensitive verdicts and the clamp behaviour can be reached in a few dozen cycles. The bench also covers reads separated by idle gaps, a read in the same cycle as the strobe, and a strobe with no reads at all.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
    typedef enum logic [1:0] {
        PH_EMPTY  = 2'd0,
        PH_STREAM = 2'd1,
        PH_JUDGE  = 2'd2,
        PH_CLOSED = 2'd3
    } cfc_phase_e;

    localparam int NUM_CNT  = 3;
    localparam int CI_ONES  = 0;
    localparam int CI_RISE  = 1;
    localparam int CI_TRANS = 2;
endpackage

// File: rtl/cfc_sat_counter.sv
module cfc_sat_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] value
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (inc && (value != TOP)) begin
            value <= value + 1'b1;
        end
    end

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (value == TOP) |=> (value == TOP)); // R7
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (value >= $past(value))); // R7
endmodule

// File: rtl/cfc_pair_tracker.sv
module cfc_pair_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic bit_in,
    output logic rise_hit,
    output logic change_hit
);
    logic prev_q;
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            seen_q <= 1'b0;
        end else if (take) begin
            prev_q <= bit_in;
            seen_q <= 1'b1;
        end
    end

    always_comb begin
        rise_hit   = take && seen_q && !prev_q && bit_in;
        change_hit = take && seen_q && (prev_q != bit_in);
    end

    AST_FIRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !seen_q) |-> !change_hit); // R5
    AST_RISE_IS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_hit |-> change_hit); // R3
    AST_GAP_KEEPS_PREV: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> ($stable(prev_q) && $stable(seen_q))); // R6
endmodule

// File: rtl/cfc_verdict_fsm.sv
module cfc_verdict_fsm
    import cfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_valid,
    input  logic end_evt,
    input  logic counts_equal,
    output logic accept,
    output logic done,
    output logic mismatch
);
    cfc_phase_e state_q;
    cfc_phase_e state_d;
    logic       mis_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mis_q <= 1'b0;
        end else if (state_q == PH_JUDGE) begin
            mis_q <= !counts_equal;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_EMPTY: begin
                if (end_evt) begin
                    state_d = PH_JUDGE;
                end else if (rd_valid) begin
                    state_d = PH_STREAM;
                end
            end
            PH_STREAM: begin
                if (end_evt) begin
                    state_d = PH_JUDGE;
                end
            end
            PH_JUDGE:  state_d = PH_CLOSED;
            PH_CLOSED: state_d = PH_CLOSED;
            default:   state_d = PH_EMPTY;
        endcase
    end

    always_comb begin
        accept   = 1'b0;
        done     = 1'b0;
        mismatch = mis_q;
        unique case (state_q)
            PH_EMPTY, PH_STREAM: accept = 1'b1;
            PH_JUDGE: begin
                done     = 1'b1;
                mismatch = !counts_equal;
            end
            PH_CLOSED: mismatch = mis_q;
            default:   accept = 1'b0;
        endcase
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && end_evt) |=> done); // R8
    AST_VERDICT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !done) |=> $stable(mismatch)); // R9
    AST_SEALED: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!accept && !done)); // R10
endmodule

// File: rtl/cfc_compactor.sv
module cfc_compactor
    import cfc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_valid,
    input  logic             rd_bit,
    input  logic             test_end,
    input  logic [CNT_W-1:0] exp_ones,
    input  logic [CNT_W-1:0] exp_rises,
    input  logic [CNT_W-1:0] exp_trans,
    output logic [CNT_W-1:0] cnt_ones,
    output logic [CNT_W-1:0] cnt_rises,
    output logic [CNT_W-1:0] cnt_trans,
    output logic             done,
    output logic             mismatch
);
    logic                 accept;
    logic                 take;
    logic                 rise_hit;
    logic                 change_hit;
    logic                 counts_equal;
    logic [NUM_CNT-1:0]   bump;
    logic [CNT_W-1:0]     cnt_vec [NUM_CNT];

    assign take = accept && rd_valid;

    cfc_pair_tracker u_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .bit_in     (rd_bit),
        .rise_hit   (rise_hit),
        .change_hit (change_hit)
    );

    always_comb begin
        bump           = '0;
        bump[CI_ONES]  = take && rd_bit;
        bump[CI_RISE]  = rise_hit;
        bump[CI_TRANS] = change_hit;
    end

    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
        cfc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (bump[gi]),
            .value (cnt_vec[gi])
        );
    end

    assign cnt_ones  = cnt_vec[CI_ONES];
    assign cnt_rises = cnt_vec[CI_RISE];
    assign cnt_trans = cnt_vec[CI_TRANS];

    assign counts_equal = (cnt_ones == exp_ones) &&
                          (cnt_rises == exp_rises) &&
                          (cnt_trans == exp_trans);

    cfc_verdict_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_valid     (rd_valid),
        .end_evt      (test_end),
        .counts_equal (counts_equal),
        .accept       (accept),
        .done         (done),
        .mismatch     (mismatch)
    );

    AST_RISE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rises <= cnt_trans); // R3
    AST_ONES_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid) |=> $stable(cnt_ones)); // R6
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept) |=> ($stable(cnt_ones) && $stable(cnt_rises) && $stable(cnt_trans))); // R10
endmodule

// File: tb/cfc_compactor_test.sv
module cfc_compactor_test;
    localparam int W    = 3;
    localparam int MAXC = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rd_valid = 1'b0;
    logic         rd_bit = 1'b0;
    logic         test_end = 1'b0;
    logic [W-1:0] exp_o = '0;
    logic [W-1:0] exp_r = '0;
    logic [W-1:0] exp_t = '0;
    logic [W-1:0] c_o;
    logic [W-1:0] c_r;
    logic [W-1:0] c_t;
    logic         done;
    logic         mismatch;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    cfc_compactor #(.CNT_W(W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_valid  (rd_valid),
        .rd_bit    (rd_bit),
        .test_end  (test_end),
        .exp_ones  (exp_o),
        .exp_rises (exp_r),
        .exp_trans (exp_t),
        .cnt_ones  (c_o),
        .cnt_rises (c_r),
        .cnt_trans (c_t),
        .done      (done),
        .mismatch  (mismatch)
    );

    // behavioural reference: phase 0 open, 1 verdict, 2 closed
    int m_ones, m_rise, m_trans, m_phase, m_prev, m_have, m_hold;

    function automatic int sat(input int v);
        return (v > MAXC) ? MAXC : v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ones = 0; m_rise = 0; m_trans = 0;
            m_phase = 0; m_prev = 0; m_have = 0; m_hold = 0;
        end else if (m_phase == 0) begin
            if (rd_valid) begin
                if (rd_bit) m_ones = sat(m_ones + 1);
                if (m_have != 0) begin
                    if (m_prev == 0 && rd_bit) m_rise = sat(m_rise + 1);
                    if (m_prev != int'(rd_bit)) m_trans = sat(m_trans + 1);
                end
                m_prev = int'(rd_bit);
                m_have = 1;
            end
            if (test_end) m_phase = 1;
        end else if (m_phase == 1) begin
            m_hold = (m_ones != int'(exp_o) || m_rise != int'(exp_r) ||
                      m_trans != int'(exp_t)) ? 1 : 0;
            m_phase = 2;
        end
    end

    task automatic check(input string tag, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            int emis;
            emis = (m_phase == 1) ?
                   ((m_ones != int'(exp_o) || m_rise != int'(exp_r) ||
                     m_trans != int'(exp_t)) ? 1 : 0) : m_hold;
            check("R2 ones", int'(c_o), m_ones);
            check("R3 rises", int'(c_r), m_rise);
            check("R4 trans", int'(c_t), m_trans);
            check("R8 done", int'(done), (m_phase == 1) ? 1 : 0);
            check("R9 mismatch", int'(mismatch), emis);
        end
    end

    task automatic do_reset();
        @(posedge clk); #2;
        rst_n = 1'b0; rd_valid = 1'b0; test_end = 1'b0;
        @(negedge clk);
        check("R1 ones in reset", int'(c_o), 0);
        check("R1 done in reset", int'(done), 0);
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;
    endtask

    task automatic rd(input logic b);
        @(posedge clk); #2;
        rd_valid = 1'b1; rd_bit = b; test_end = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            rd_valid = 1'b0; test_end = 1'b0;
        end
    endtask

    // strobe with no read; returns while the verdict cycle is current
    task automatic finish_run();
        @(posedge clk); #2;
        rd_valid = 1'b0; test_end = 1'b1;
        @(posedge clk); #2;
        test_end = 1'b0;
    endtask

    task automatic run_str(input logic [3:0] pat, input int expm, input string tag);
        do_reset();
        exp_o = 3'd2; exp_r = 3'd1; exp_t = 3'd1;
        for (int i = 3; i >= 0; i--) rd(pat[i]);
        finish_run();
        @(negedge clk);
        check({tag, " done"}, int'(done), 1);
        check({tag, " mismatch"}, int'(mismatch), expm);
        idle(1);
        @(negedge clk);
        check("R9 verdict held", int'(mismatch), expm);
        check("R8 done single", int'(done), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        check("R1 ones", int'(c_o), 0);
        check("R1 rises", int'(c_r), 0);
        check("R1 trans", int'(c_t), 0);
        check("R1 mismatch", int'(mismatch), 0);

        // R11 ordering-sensitive verdicts
        run_str(4'b0011, 0, "R11 0011");
        run_str(4'b1100, 1, "R11 1100");
        run_str(4'b1010, 1, "R11 1010");
        run_str(4'b0101, 1, "R11 0101");

        // R5 first read, R6 gaps
        do_reset();
        rd(1'b1); idle(1);
        @(negedge clk);
        check("R5 first read trans", int'(c_t), 0);
        check("R5 first read rises", int'(c_r), 0);
        rd(1'b0); idle(3); rd(1'b1); idle(2); rd(1'b1); idle(1);
        @(negedge clk);
        check("R6 trans across gaps", int'(c_t), 2);
        check("R6 rises across gaps", int'(c_r), 1);
        check("R2 ones across gaps", int'(c_o), 3);

        // R7 saturation
        do_reset();
        for (int i = 0; i < 20; i++) rd(i[0]);
        idle(1);
        @(negedge clk);
        check("R7 ones clamp", int'(c_o), MAXC);
        check("R7 rises clamp", int'(c_r), MAXC);
        check("R7 trans clamp", int'(c_t), MAXC);

        // R8 read with strobe counted, R10 sealed afterwards
        do_reset();
        exp_o = 3'd2; exp_r = 3'd1; exp_t = 3'd1;
        rd(1'b0); rd(1'b1);
        @(posedge clk); #2;
        rd_valid = 1'b1; rd_bit = 1'b1; test_end = 1'b1;
        @(posedge clk); #2;
        rd_valid = 1'b0; test_end = 1'b0;
        @(negedge clk);
        check("R8 same-cycle read counted", int'(c_o), 2);
        check("R8 done", int'(done), 1);
        check("R9 match", int'(mismatch), 0);
        rd(1'b0); rd(1'b1);
        @(posedge clk); #2;
        rd_valid = 1'b1; rd_bit = 1'b0; test_end = 1'b1;
        @(posedge clk); #2;
        rd_valid = 1'b0; test_end = 1'b0;
        @(negedge clk);
        check("R10 ones frozen", int'(c_o), 2);
        check("R10 trans frozen", int'(c_t), 1);
        check("R10 no second done", int'(done), 0);
        check("R10 verdict kept", int'(mismatch), 0);

        // strobe with no reads
        do_reset();
        exp_o = 3'd0; exp_r = 3'd0; exp_t = 3'd1;
        finish_run();
        @(negedge clk);
        check("R9 empty run mismatch", int'(mismatch), 1);
        check("R8 empty run done", int'(done), 1);

        idle(2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule